// File: doc/BRIEF.md
# Two-Wire Memory Slave Address Front-End

This block sits between the two bus lines of a two-wire serial memory and a simple internal memory port. It cleans both lines of short spikes, finds start and stop conditions, and shifts in the first byte after a start. That byte selects the slave. Its upper nibble must carry a fixed prefix, and two of its bits must equal two pin-strapped select inputs. One further bit is not compared and becomes the top bit of the memory address. The last bit chooses between read and write.

On a write selection the block takes in two word-address bytes, which form a 17-bit address together with the page bit. It then turns every following data byte into a one-cycle write strobe. The address steps by one after each data byte. A write-lock input keeps every strobe away from the memory, but the bytes are still acknowledged. On a read selection the block raises a one-cycle read request at the stored address. Serialising the read data is left to the rest of the slave. Acknowledges use an active-high output enable that only ever pulls SDA low.

Top module: `eeprom_addr_front`

## Requirements
- R1: SDA falling while SCL is high is a start condition, and SDA rising while SCL is high is a stop. Either one abandons the transfer in progress and resets the bit counter. After a start the next eight bits form a new selection byte.
- R2: A level on SCL or SDA that lasts fewer than FILT_LEN (default 3) system-clock samples is ignored. A spike of two clock cycles cannot add a bit or create a start or stop.
- R3: Bits 7:4 of the selection byte must be 4'b1010, or the byte is not accepted.
- R4: Bit 3 of the selection byte must equal strap_i[1] and bit 2 must equal strap_i[0], or the byte is not accepted.
- R5: Bit 1 of the selection byte is not compared. It becomes bit 16 of the memory address.
- R6: Bit 0 of the selection byte is 0 for a write and 1 for a read. An accepted read raises mem_rd_o for one cycle with mem_addr_o = {bit 1, the stored 16-bit word address}.
- R7: On an accepted selection byte, sda_oe_o is high during the ninth SCL clock. A rejected byte gets no acknowledge, and the block stays silent until the next start.
- R8: After an accepted write selection, two word-address bytes follow, high byte first, and each is acknowledged. The memory address is {bit 1, high byte, low byte}.
- R9: Each data byte after the word address is acknowledged and produces a write strobe carrying the byte and the current address. The address then increments by one.
- R10: While wr_lock_i is high, data bytes are still acknowledged but mem_we_o stays low.
- R11: sda_oe_o changes only while the filtered SCL is low.
- R12: mem_we_o and mem_rd_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| strap_i | input | 2 | Pin-strapped select bits compared with selection bits 3:2 |
| wr_lock_i | input | 1 | High blocks every memory write |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain acknowledge) |
| mem_addr_o | output | 17 | Memory address {page bit, high byte, low byte} |
| mem_wdata_o | output | 8 | Data byte for the write strobe |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rd_o | output | 1 | One-cycle read request |

## Verification
The falling SCL edge that closes a data byte does two things in the same cycle: it raises the acknowledge enable and it issues the write strobe. Under the write lock it must do only the first. The bench sends data bytes with the lock both low and high. At the ninth clock it samples the resolved bus line to check the acknowledge. A scoreboard monitor pops an expected write for each strobe, flags any strobe that nothing expected, and must find its queue empty at the end. Spikes injected into the same bytes test the filter against the bit counter and the start/stop detector on the same edges.

// File: rtl/eafe_pkg.sv
`timescale 1ns/1ps
package eafe_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 1 + 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_HI,
        ST_LO,
        ST_DATA,
        ST_RDH
    } xfer_st_e;
endpackage

// File: rtl/eafe_line_filter.sv
`timescale 1ns/1ps
module eafe_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   clean;
    } flt_t;

    flt_t q, d;
    logic sampled;

    assign sampled = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_i};
        if (sampled != q.clean) begin
            if (q.cnt == LAST) begin
                d.clean = sampled;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= {SYNC_STAGES{RST_VAL}};
            q.cnt   <= '0;
            q.clean <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.clean;

    // R2
    flt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.clean) |-> (q.clean == $past(sampled)));
endmodule

// File: rtl/eafe_bus_cond.sv
`timescale 1ns/1ps
module eafe_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign start_o    = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_o     = scl_i & q.scl & ~q.sda & sda_i;
    assign scl_rise_o = scl_i & ~q.scl;
    assign scl_fall_o = ~scl_i & q.scl;
endmodule

// File: rtl/eafe_xfer_ctrl.sv
`timescale 1ns/1ps
module eafe_xfer_ctrl
    import eafe_pkg::*;
#(
    parameter logic [3:0] PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic [1:0]        strap_i,
    input  logic              wr_lock_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_rd_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        xfer_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic              oe;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic              we;
        logic              rd;
    } ctl_t;

    ctl_t q, d;
    logic sel_hit;
    logic receiving;

    assign sel_hit   = (q.sh[7:4] == PREFIX) && (q.sh[3:2] == strap_i);
    assign receiving = (q.st == ST_DEV) || (q.st == ST_HI) ||
                       (q.st == ST_LO)  || (q.st == ST_DATA);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.rd = 1'b0;
        if (start_i) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.ack = 1'b0;
            d.oe  = 1'b0;
        end else if (stop_i) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.ack = 1'b0;
            d.oe  = 1'b0;
        end else if (receiving) begin
            if (scl_rise_i && !q.ack && (q.cnt != FULL)) begin
                d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                d.cnt = q.cnt + CNT_W'(1);
            end
            if (scl_fall_i) begin
                if (q.ack) begin
                    d.oe  = 1'b0;
                    d.ack = 1'b0;
                    d.cnt = '0;
                    case (q.st)
                        ST_DEV:  d.st = q.rw ? ST_RDH : ST_HI;
                        ST_HI:   d.st = ST_LO;
                        ST_LO:   d.st = ST_DATA;
                        ST_DATA: d.addr = q.addr + ADDR_W'(1);
                        default: d.st = ST_IDLE;
                    endcase
                end else if (q.cnt == FULL) begin
                    case (q.st)
                        ST_DEV: begin
                            if (sel_hit) begin
                                d.oe             = 1'b1;
                                d.ack            = 1'b1;
                                d.rw             = q.sh[0];
                                d.addr[ADDR_W-1] = q.sh[1];
                                d.rd             = q.sh[0];
                            end else begin
                                d.st  = ST_IDLE;
                                d.cnt = '0;
                            end
                        end
                        ST_HI: begin
                            d.oe  = 1'b1;
                            d.ack = 1'b1;
                            d.addr[2*BYTE_W-1:BYTE_W] = q.sh;
                        end
                        ST_LO: begin
                            d.oe  = 1'b1;
                            d.ack = 1'b1;
                            d.addr[BYTE_W-1:0] = q.sh;
                        end
                        ST_DATA: begin
                            d.oe    = 1'b1;
                            d.ack   = 1'b1;
                            d.wdata = q.sh;
                            d.we    = !wr_lock_i;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;
    assign mem_we_o    = q.we;
    assign mem_rd_o    = q.rd;

    // R11
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_lvl_i);

    // R11
    oe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.oe) |-> (!scl_lvl_i || $past(start_i || stop_i)));

    // R12
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd |=> !q.rd);

    // R10
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> !$past(wr_lock_i));

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.cnt == '0 && !q.oe && q.st == ST_DEV));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);
endmodule

// File: rtl/eeprom_addr_front.sv
`timescale 1ns/1ps
module eeprom_addr_front
    import eafe_pkg::*;
#(
    parameter int         FILT_LEN    = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] PREFIX      = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              wr_lock_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_rd_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] clean_w;
    logic start_w, stop_w, rise_w, fall_w;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_flt
        eafe_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .RST_VAL    (1'b1)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[g]),
            .clean_o(clean_w[g])
        );
    end

    eafe_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (clean_w[0]),
        .sda_i     (clean_w[1]),
        .start_o   (start_w),
        .stop_o    (stop_w),
        .scl_rise_o(rise_w),
        .scl_fall_o(fall_w)
    );

    eafe_xfer_ctrl #(.PREFIX(PREFIX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .scl_rise_i (rise_w),
        .scl_fall_i (fall_w),
        .scl_lvl_i  (clean_w[0]),
        .sda_lvl_i  (clean_w[1]),
        .strap_i    (strap_i),
        .wr_lock_i  (wr_lock_i),
        .sda_oe_o   (sda_oe_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o),
        .mem_we_o   (mem_we_o),
        .mem_rd_o   (mem_rd_o)
    );
endmodule

// File: tb/eeprom_addr_front_test.sv
`timescale 1ns/1ps
module eeprom_addr_front_test;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        lock = 1'b0;
    logic        sda_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_rd;
    logic        sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    eeprom_addr_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .wr_lock_i  (lock),
        .sda_oe_o   (sda_oe),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata),
        .mem_we_o   (mem_we),
        .mem_rd_o   (mem_rd)
    );

    typedef struct {
        bit        rd;
        bit [16:0] addr;
        bit [7:0]  data;
        string     req;
    } item_t;

    item_t exp_q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // glitch 1: short SCL spike in a low phase; glitch 2: short SDA rise in a high phase of a 0 bit
    task automatic send_bits(input logic [7:0] b, input int nbits, input int glitch);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1;
            if (glitch == 2 && b[i] == 1'b0) begin
                tick(8); sda_m = 1'b1; tick(2); sda_m = 1'b0; tick(2 * Q - 10);
            end else begin
                tick(2 * Q);
            end
            scl_m = 1'b0;
            if (glitch == 1 && i == 4) begin
                tick(5); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q - 7);
            end else begin
                tick(Q);
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input string req, input int glitch);
        bit got;
        send_bits(b, 8, glitch);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        got = !sda_bus;
        chk(got == exp_ack, req, "ack", got, exp_ack);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic expect_wr(input bit [16:0] a, input bit [7:0] dt, input string req);
        item_t it;
        it.rd = 1'b0; it.addr = a; it.data = dt; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic expect_rd(input bit [16:0] a, input string req);
        item_t it;
        it.rd = 1'b1; it.addr = a; it.data = '0; it.req = req;
        exp_q.push_back(it);
    endtask

    // scoreboard monitor
    bit we_prev = 1'b0;
    bit rd_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we && we_prev) chk(1'b0, "R12", "write strobe width", 2, 1);
            if (mem_rd && rd_prev) chk(1'b0, "R12", "read strobe width", 2, 1);
            if (mem_we || mem_rd) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected strobe addr", mem_addr, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(mem_rd == it.rd, it.req, "strobe kind", mem_rd, it.rd);
                    chk(mem_addr == it.addr, it.req, "strobe addr", mem_addr, it.addr);
                    if (!it.rd)
                        chk(mem_wdata == it.data, it.req, "write data", mem_wdata, it.data);
                end
            end
            we_prev = mem_we;
            rd_prev = mem_rd;
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        tick(5);
        chk(sda_oe == 1'b0, "R7", "reset oe", sda_oe, 0);
        chk(mem_we == 1'b0, "R12", "reset we", mem_we, 0);
        chk(mem_rd == 1'b0, "R12", "reset rd", mem_rd, 0);
        rst_n = 1'b1;
        tick(10);

        // R8 R9: write with page bit 1, two data bytes
        bus_start();
        send_byte(8'hAA, 1'b1, "R7", 0);
        send_byte(8'h12, 1'b1, "R8", 0);
        send_byte(8'h34, 1'b1, "R8", 0);
        expect_wr(17'h11234, 8'h5A, "R9");
        send_byte(8'h5A, 1'b1, "R9", 0);
        expect_wr(17'h11235, 8'hC3, "R9");
        send_byte(8'hC3, 1'b1, "R9", 0);
        bus_stop();

        // R2 R5: page bit 0, spikes on both lines
        bus_start();
        send_byte(8'hA8, 1'b1, "R5", 0);
        send_byte(8'h0F, 1'b1, "R2", 1);
        send_byte(8'hF0, 1'b1, "R2", 2);
        expect_wr(17'h00FF0, 8'h99, "R2");
        send_byte(8'h99, 1'b1, "R2", 2);
        bus_stop();

        // R3: wrong prefix, then silence until next start
        bus_start();
        send_byte(8'hBA, 1'b0, "R3", 0);
        send_byte(8'h00, 1'b0, "R7", 0);
        send_byte(8'h55, 1'b0, "R7", 0);
        bus_stop();

        // R4: strap mismatch both ways, then another strap value
        bus_start();
        send_byte(8'hA4, 1'b0, "R4", 0);
        bus_stop();
        bus_start();
        send_byte(8'hAE, 1'b0, "R4", 0);
        bus_stop();
        strap = 2'b01;
        bus_start();
        send_byte(8'hA6, 1'b1, "R4", 0);
        send_byte(8'h00, 1'b1, "R8", 0);
        send_byte(8'h07, 1'b1, "R8", 0);
        expect_wr(17'h10007, 8'h11, "R4");
        send_byte(8'h11, 1'b1, "R4", 0);
        bus_stop();
        strap = 2'b10;

        // R10: write lock keeps acks, blocks strobes
        lock = 1'b1;
        bus_start();
        send_byte(8'hAA, 1'b1, "R10", 0);
        send_byte(8'h20, 1'b1, "R10", 0);
        send_byte(8'h00, 1'b1, "R10", 0);
        send_byte(8'h55, 1'b1, "R10", 0);
        send_byte(8'h66, 1'b1, "R10", 0);
        bus_stop();
        lock = 1'b0;
        tick(Q);

        // R1: repeated start mid address, partial byte then restart
        bus_start();
        send_byte(8'hAA, 1'b1, "R1", 0);
        send_byte(8'h77, 1'b1, "R1", 0);
        send_bits(8'hE0, 3, 0);
        bus_start();
        send_byte(8'hA8, 1'b1, "R1", 0);
        send_byte(8'h01, 1'b1, "R1", 0);
        send_byte(8'h02, 1'b1, "R1", 0);
        expect_wr(17'h00102, 8'h03, "R1");
        send_byte(8'h03, 1'b1, "R1", 0);
        bus_stop();

        // R1: stop after partial byte, then a clean write
        bus_start();
        send_bits(8'hAA, 5, 0);
        bus_stop();
        bus_start();
        send_byte(8'hAA, 1'b1, "R1", 0);
        send_byte(8'h3C, 1'b1, "R8", 0);
        send_byte(8'hC3, 1'b1, "R8", 0);
        expect_wr(17'h13CC3, 8'hE7, "R1");
        send_byte(8'hE7, 1'b1, "R1", 0);
        bus_stop();

        // R6 R5: read after setting word address, page bit from read byte
        bus_start();
        send_byte(8'hAA, 1'b1, "R6", 0);
        send_byte(8'h40, 1'b1, "R6", 0);
        send_byte(8'h10, 1'b1, "R6", 0);
        bus_start();
        expect_rd(17'h04010, "R6");
        send_byte(8'hA9, 1'b1, "R6", 0);
        bus_stop();

        tick(4 * Q);
        chk(exp_q.size() == 0, "R9", "pending strobes", exp_q.size(), 0);
        chk(sda_oe == 1'b0, "R7", "oe after stop", sda_oe, 0);
        finish_up();
    end
endmodule